// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block moves a block of words between one peripheral and memory without the processor touching each word. The processor loads a start address, a word count and a configuration word through a small register port, and that port is open only while the bus grant input is low. Setting the start bit launches the transfer. From then on the engine asks for the system bus, places addresses on the memory address lines and drives memory read or write strobes. For each word it pulses an acknowledge back to the peripheral. The data itself travels straight between peripheral and memory: the engine supplies only addresses and strobes.

Three bus-sharing policies are available. Burst mode holds the bus until the whole block is done. Steal mode gives the bus back after each word. Idle-slot mode never requests the bus and moves a word only in cycles that the processor marks as idle. When the count runs out, a sticky done flag drives the interrupt line. The flag stays set until the processor reads the configuration register or writes its clear bit.

Top module: `dma_engine`

## Requirements
- R1: With bus grant low and no transfer active, writing select 0 (address), select 1 (count) or select 2 (configuration: bit 1 direction, bits 3:2 mode) stores the value. A read of the same select returns it in the cycle the read strobe is high. Configuration bit 0 reads back as "transfer active", and bit 4 reads back as the done flag.
- R2: While bus grant is high, register writes have no effect, including a start request, and reads return zero.
- R3: Mode 0 (burst): bus request rises once per transfer and stays high until the last word has moved. No word moves while bus request is high and grant is low.
- R4: Mode 1 (steal): exactly one word moves per grant. Bus request then drops, and it rises again only after grant has gone low, so an N-word transfer raises bus request N times.
- R5: Mode 2 (idle-slot): bus request never rises. A word moves only in a cycle where the CPU-idle input is high.
- R6: Words are issued at consecutive addresses, starting at the programmed address. When the transfer ends, the address register reads start+N and the count register reads 0.
- R7: Starting with a count of 0 sets done (interrupt high) on the start write itself and never raises bus request.
- R8: A word moves only in a cycle where the device request is high. The device acknowledge is high for exactly that cycle, once per word.
- R9: On completion, configuration bit 0 reads 0, done sets and the interrupt stays high. A read of select 2 clears done, and the interrupt then goes low.
- R10: While a transfer is active, register writes are ignored, except that a write to select 2 with bit 5 set clears done.
- R11: Direction bit 1 = 1 marks each word with the memory write strobe, and 0 marks it with the memory read strobe. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select: 0 address, 1 count, 2 configuration/status |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regWrData | input | DW | Register write data |
| regRdData | output | DW | Register read data (zero while granted) |
| busReq | output | 1 | Bus request to the arbiter |
| busGrant | input | 1 | Bus grant; high means the engine owns the bus |
| cpuIdle | input | 1 | Processor reports an idle bus cycle |
| memAddr | output | AW | Memory address |
| memRd | output | 1 | Memory read strobe (memory to device) |
| memWr | output | 1 | Memory write strobe (device to memory) |
| devReq | input | 1 | Device data request |
| devAck | output | 1 | Device acknowledge, one cycle per word |
| irq | output | 1 | Interrupt, follows the sticky done flag |

## Verification
The block is exercised in burst mode with the device request held high, in burst mode with the request held low at first, in steal mode under an arbiter that grants one cycle late, and in idle-slot mode with the idle input toggling. The count of bus-request rises is what separates burst from steal. Moves lining up with the idle input is what separates idle-slot mode from both. The stalled-request phase shows that words wait for the device and are not released by the grant alone. Separate runs cover a zero count, register access under a forced grant, and writes landing during an active transfer, including the clear bit.

// File: rtl/dma_engine_pkg.sv
package dma_engine_pkg;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CFG   = 2'd2;

  localparam int CB_START   = 0;
  localparam int CB_DIR     = 1;
  localparam int CB_MODE_LO = 2;
  localparam int CB_DONE    = 4;
  localparam int CB_CLEAR   = 5;

  localparam logic [1:0] MODE_BURST = 2'd0;
  localparam logic [1:0] MODE_STEAL = 2'd1;
  localparam logic [1:0] MODE_SLOT  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_GAP   = 2'd2,
    ST_SNEAK = 2'd3
  } ctrlState_e;

  typedef struct packed {
    logic move;
    logic finish;
    logic active;
  } dmaStrobe_t;

endpackage

// File: rtl/dma_engine_dp.sv
module dma_engine_dp
  import dma_engine_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    regSel,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  input  logic          busGrant,
  input  dmaStrobe_t    strobe,
  output logic          startReq,
  output logic          countZero,
  output logic          countOne,
  output logic [1:0]    modeOut,
  output logic          dirOut,
  output logic [AW-1:0] memAddr,
  output logic          doneOut
);

  logic [AW-1:0] addrReg;
  logic [CW-1:0] countReg;
  logic [1:0]    modeReg;
  logic          dirReg;
  logic          doneReg;

  logic cpuAccess;
  logic wrHit;
  logic cfgWrite;
  logic cfgCtrlWrite;
  logic clearHit;

  assign cpuAccess    = !busGrant;
  assign wrHit        = regWrEn && cpuAccess;
  assign cfgWrite     = wrHit && !strobe.active;
  assign cfgCtrlWrite = cfgWrite && (regSel == SEL_CFG);
  assign startReq     = cfgCtrlWrite && regWrData[CB_START];
  assign clearHit     = (wrHit && (regSel == SEL_CFG) && regWrData[CB_CLEAR]) ||
                        (regRdEn && cpuAccess && (regSel == SEL_CFG));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      countReg <= '0;
      modeReg  <= MODE_BURST;
      dirReg   <= 1'b0;
      doneReg  <= 1'b0;
    end else begin
      if (cfgWrite && (regSel == SEL_ADDR)) begin
        addrReg <= regWrData[AW-1:0];
      end else if (strobe.move) begin
        addrReg <= addrReg + AW'(1);
      end

      if (cfgWrite && (regSel == SEL_COUNT)) begin
        countReg <= regWrData[CW-1:0];
      end else if (strobe.move) begin
        countReg <= countReg - CW'(1);
      end

      if (cfgCtrlWrite) begin
        dirReg  <= regWrData[CB_DIR];
        modeReg <= regWrData[CB_MODE_LO +: 2];
      end

      if (strobe.finish) begin
        doneReg <= 1'b1;
      end else if (clearHit) begin
        doneReg <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (cpuAccess) begin
      case (regSel)
        SEL_ADDR:  regRdData = DW'(addrReg);
        SEL_COUNT: regRdData = DW'(countReg);
        SEL_CFG: begin
          regRdData[CB_START]         = strobe.active;
          regRdData[CB_DIR]           = dirReg;
          regRdData[CB_MODE_LO +: 2]  = modeReg;
          regRdData[CB_DONE]          = doneReg;
        end
        default: regRdData = '0;
      endcase
    end
  end

  assign countZero = (countReg == '0);
  assign countOne  = (countReg == CW'(1));
  assign modeOut   = cfgCtrlWrite ? regWrData[CB_MODE_LO +: 2] : modeReg;
  assign dirOut    = dirReg;
  assign memAddr   = addrReg;
  assign doneOut   = doneReg;

endmodule

// File: rtl/dma_engine_ctrl.sv
module dma_engine_ctrl
  import dma_engine_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       countZero,
  input  logic       countOne,
  input  logic [1:0] mode,
  input  logic       busGrant,
  input  logic       cpuIdle,
  input  logic       devReq,
  output dmaStrobe_t strobe,
  output logic       busReq
);

  ctrlState_e state;
  ctrlState_e stateNext;
  logic       move;
  logic       finish;

  always_comb begin
    stateNext = state;
    move      = 1'b0;
    finish    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (countZero) begin
            finish = 1'b1;
          end else if (mode == MODE_SLOT) begin
            stateNext = ST_SNEAK;
          end else begin
            stateNext = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        move = busGrant && devReq;
        if (move) begin
          if (countOne) begin
            finish    = 1'b1;
            stateNext = ST_IDLE;
          end else if (mode == MODE_STEAL) begin
            stateNext = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (!busGrant) begin
          stateNext = ST_REQ;
        end
      end
      ST_SNEAK: begin
        move = cpuIdle && devReq;
        if (move && countOne) begin
          finish    = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign strobe.move   = move;
  assign strobe.finish = finish;
  assign strobe.active = (state != ST_IDLE);
  assign busReq        = (state == ST_REQ);

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_engine_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    regSel,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  output logic          busReq,
  input  logic          busGrant,
  input  logic          cpuIdle,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  output logic          memWr,
  input  logic          devReq,
  output logic          devAck,
  output logic          irq
);

  dmaStrobe_t strobe;
  logic       startReq;
  logic       countZero;
  logic       countOne;
  logic [1:0] mode;
  logic       dir;
  logic       done;

  dma_engine_dp #(.AW(AW), .CW(CW), .DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regSel    (regSel),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .busGrant  (busGrant),
    .strobe    (strobe),
    .startReq  (startReq),
    .countZero (countZero),
    .countOne  (countOne),
    .modeOut   (mode),
    .dirOut    (dir),
    .memAddr   (memAddr),
    .doneOut   (done)
  );

  dma_engine_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .countZero (countZero),
    .countOne  (countOne),
    .mode      (mode),
    .busGrant  (busGrant),
    .cpuIdle   (cpuIdle),
    .devReq    (devReq),
    .strobe    (strobe),
    .busReq    (busReq)
  );

  assign memRd  = strobe.move && !dir;
  assign memWr  = strobe.move && dir;
  assign devAck = strobe.move;
  assign irq    = done;

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk (
  input logic clk,
  input logic rstN,
  input logic busReq,
  input logic busGrant,
  input logic cpuIdle,
  input logic memRd,
  input logic memWr,
  input logic devReq,
  input logic devAck,
  input logic irq
);

  assert_ack_needs_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    devAck |-> devReq);

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  assert_bus_owned_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> (busGrant || cpuIdle));

  assert_wait_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGrant) |-> !devAck);

  assert_done_frees_bus_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> !busReq);

endmodule

bind dma_engine dma_engine_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busReq   (busReq),
  .busGrant (busGrant),
  .cpuIdle  (cpuIdle),
  .memRd    (memRd),
  .memWr    (memWr),
  .devReq   (devReq),
  .devAck   (devAck),
  .irq      (irq)
);

// File: tb/dma_engine_test.sv
module dma_engine_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;
  logic        busReq;
  logic        busGrant;
  logic        cpuIdle = 1'b0;
  logic [15:0] memAddr;
  logic        memRd, memWr;
  logic        devReq = 1'b0;
  logic        devAck;
  logic        irq;

  logic arbGrant = 1'b0;
  logic forceGrant = 1'b0;
  logic idleToggle = 1'b0;
  logic slotMode = 1'b0;

  int checks = 0;
  int errors = 0;
  int moves = 0;
  int reqRises = 0;
  logic prevReq = 1'b0;
  logic [16:0] expQ[$];

  always #5 clk = ~clk;

  assign busGrant = arbGrant | forceGrant;

  always @(posedge clk) arbGrant <= rstN && busReq;

  always @(posedge clk) begin
    #1;
    cpuIdle = idleToggle ? ~cpuIdle : 1'b0;
  end

  dma_engine uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .busReq(busReq), .busGrant(busGrant),
    .cpuIdle(cpuIdle), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .devReq(devReq), .devAck(devAck), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops scoreboard entries as words move
  always @(negedge clk) begin
    if (rstN) begin
      if (busReq && !prevReq) reqRises++;
      prevReq = busReq;
      if (devAck || memRd || memWr) begin
        moves++;
        check(devReq, "R8 move without device request", 32'(devReq), 1);
        check(devAck, "R8 strobe without acknowledge", 32'(devAck), 1);
        check(memRd ^ memWr, "R11 strobe exclusivity", {30'd0, memWr, memRd}, 1);
        if (slotMode) check(cpuIdle, "R5 move outside idle slot", 32'(cpuIdle), 1);
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected word", 32'({memWr, memAddr}), 0);
        end else begin
          logic [16:0] e;
          e = expQ.pop_front();
          check({memWr, memAddr} == e, "R6 R11 word address/direction", 32'({memWr, memAddr}), 32'(e));
        end
      end
    end
  end

  task automatic regWrite(input logic [1:0] sel, input logic [15:0] d);
    @(posedge clk); #1;
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [15:0] d);
    @(posedge clk); #1;
    regSel = sel; regRdEn = 1'b1;
    @(negedge clk);
    d = regRdData;
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic pushWords(input logic [15:0] base, input int n, input logic w);
    for (int i = 0; i < n; i++) expQ.push_back({w, base + 16'(i)});
  endtask

  task automatic waitIrq(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1'b1; break; end
    end
    check(seen, tag, 32'(seen), 1);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    logic [15:0] rd;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!busReq && !irq && !memRd && !memWr && !devAck, "R1 reset outputs quiet",
          {27'd0, busReq, irq, memRd, memWr, devAck}, 0);
    regRead(2'd0, rd);
    check(rd == 16'h0, "R1 reset address", rd, 0);

    // R1 register readback
    regWrite(2'd0, 16'h1234);
    regWrite(2'd1, 16'h0055);
    regWrite(2'd2, 16'h000A);
    regRead(2'd0, rd); check(rd == 16'h1234, "R1 address readback", rd, 16'h1234);
    regRead(2'd1, rd); check(rd == 16'h0055, "R1 count readback", rd, 16'h0055);
    regRead(2'd2, rd); check(rd == 16'h000A, "R1 configuration readback", rd, 16'h000A);

    // R2 blocked while granted
    forceGrant = 1'b1;
    regWrite(2'd0, 16'hBEEF);
    regRead(2'd0, rd); check(rd == 16'h0, "R2 read while granted", rd, 0);
    regWrite(2'd2, 16'h0001);
    repeat (3) @(negedge clk);
    check(!busReq && reqRises == 0, "R2 start ignored while granted", 32'(reqRises), 0);
    forceGrant = 1'b0;
    regRead(2'd0, rd); check(rd == 16'h1234, "R2 write ignored while granted", rd, 16'h1234);
    regRead(2'd2, rd); check(rd[0] == 1'b0, "R2 no transfer started", rd, 0);

    // R3 burst, device-to-memory
    devReq = 1'b1; reqRises = 0; moves = 0;
    regWrite(2'd0, 16'h0100);
    regWrite(2'd1, 16'd3);
    pushWords(16'h0100, 3, 1'b1);
    regWrite(2'd2, 16'h0003);
    waitIrq("R9 burst completion");
    check(reqRises == 1, "R3 single bus request in burst", 32'(reqRises), 1);
    check(moves == 3 && expQ.size() == 0, "R3 burst word total", 32'(moves), 3);
    regRead(2'd0, rd); check(rd == 16'h0103, "R6 final address", rd, 16'h0103);
    regRead(2'd1, rd); check(rd == 16'h0, "R6 final count", rd, 0);
    check(irq, "R9 interrupt held", 32'(irq), 1);
    regRead(2'd2, rd);
    check(rd[0] == 1'b0 && rd[4] == 1'b1, "R9 start clear, done set", rd, 16'h0012);
    @(negedge clk);
    check(!irq, "R9 read clears done", 32'(irq), 0);

    // R8 device request gating (burst, memory read)
    devReq = 1'b0; reqRises = 0; moves = 0;
    regWrite(2'd0, 16'h0400);
    regWrite(2'd1, 16'd2);
    regWrite(2'd2, 16'h0001);
    repeat (6) @(negedge clk);
    check(moves == 0, "R8 no move without request", 32'(moves), 0);
    check(busReq, "R3 request held while waiting", 32'(busReq), 1);
    pushWords(16'h0400, 2, 1'b0);
    @(posedge clk); #1 devReq = 1'b1;
    waitIrq("R8 gated burst completion");
    check(moves == 2 && reqRises == 1, "R8 one ack per word", 32'(moves), 2);
    regRead(2'd2, rd);

    // R4 steal, memory read
    reqRises = 0; moves = 0;
    regWrite(2'd0, 16'h0200);
    regWrite(2'd1, 16'd4);
    pushWords(16'h0200, 4, 1'b0);
    regWrite(2'd2, 16'h0005);
    waitIrq("R4 steal completion");
    check(reqRises == 4, "R4 one request per word", 32'(reqRises), 4);
    check(moves == 4 && expQ.size() == 0, "R4 steal word total", 32'(moves), 4);

    // R5 idle-slot with R10 writes during active
    reqRises = 0; moves = 0; devReq = 1'b1;
    regWrite(2'd0, 16'h0300);
    regWrite(2'd1, 16'd3);
    regWrite(2'd2, 16'h000B);
    regWrite(2'd0, 16'h7777);
    regWrite(2'd1, 16'd9);
    check(irq, "R10 done kept before clear", 32'(irq), 1);
    regWrite(2'd2, 16'h0020);
    @(negedge clk);
    check(!irq, "R10 clear accepted while active", 32'(irq), 0);
    check(moves == 0, "R5 no move without idle slot", 32'(moves), 0);
    pushWords(16'h0300, 3, 1'b1);
    slotMode = 1'b1; idleToggle = 1'b1;
    waitIrq("R5 idle-slot completion");
    idleToggle = 1'b0; slotMode = 1'b0;
    check(reqRises == 0, "R5 bus never requested", 32'(reqRises), 0);
    regRead(2'd0, rd); check(rd == 16'h0303, "R10 address write ignored while active", rd, 16'h0303);
    regRead(2'd1, rd); check(rd == 16'h0, "R10 count write ignored while active", rd, 0);
    regRead(2'd2, rd);

    // R7 zero count
    reqRises = 0; moves = 0;
    regWrite(2'd1, 16'd0);
    regWrite(2'd2, 16'h0001);
    @(negedge clk);
    check(irq, "R7 immediate done", 32'(irq), 1);
    repeat (4) @(negedge clk);
    check(reqRises == 0 && moves == 0, "R7 no bus request", 32'(reqRises), 0);
    regRead(2'd2, rd);
    check(rd[0] == 1'b0 && rd[4] == 1'b1, "R7 status after zero start", rd, 16'h0010);

    check(expQ.size() == 0, "R6 scoreboard drained", 32'(expQ.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule